// File: doc/BRIEF.md
# SMT Reorder-Buffer Capacity Allocator

This block decides how many reorder-buffer slots each hardware thread may occupy when several threads share one buffer. It is fed a sharing policy, the buffer's total capacity, a threshold value, the occupancy that the buffer reports for each thread, and a mask of the threads that are currently running. From these it keeps a registered per-thread limit. It also produces, without a register stage, the free slots left for each thread and the free slots left in the whole buffer. Dispatch logic uses these to stall a thread that has reached its share.

The limits are loaded at reset from the selected policy. After that they are recomputed only when the active-thread mask changes value. The policy decides what a recompute does. The shared policy leaves every thread at the full capacity. The split policy divides the capacity evenly among the threads that are running. The cap policy gives a lone running thread the whole buffer. An encoding of the policy input that is not defined is treated as the shared policy and is reported on an error output.

Top module: `rob_share_alloc`

## Requirements
- R1: During reset each thread's limit is loaded by policy code. Code 0 (shared) and code 3 (undefined) load the capacity. Code 1 (split) loads the capacity divided by NUM_THREADS, truncated. Code 2 (cap) loads the threshold input.
- R2: Under code 0 the limits stay at the capacity across any number of active-mask changes.
- R3: Under code 1, at the first clock edge where the active mask differs from its value at the previous edge and has n > 0 bits set, every thread whose mask bit is set gets the capacity divided by n, truncated. Threads whose bit is clear keep their limit. Bit k of the mask is thread k.
- R4: Under code 2, a mask change that leaves exactly one thread active sets that thread's limit to the capacity. A change that leaves two or more threads active leaves every limit unchanged.
- R5: A change to an all-zero active mask leaves every limit unchanged.
- R6: A thread's free count is its limit minus its occupancy, and is 0 when the occupancy exceeds the limit.
- R7: The global free count is the capacity minus the sum of all thread occupancies, and is 0 when that sum exceeds the capacity.
- R8: Code 3 on the policy input drives the error output to 1 and behaves exactly as code 0. Codes 0 to 2 drive it to 0.
- R9: At an edge where the active mask equals its value at the previous edge, the limits do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the policy limits |
| policy_i | input | 2 | Sharing policy code (0 shared, 1 split, 2 cap, 3 undefined) |
| capacity_i | input | CNT_W | Total buffer capacity in entries |
| threshold_i | input | CNT_W | Per-thread limit under the cap policy |
| active_i | input | NUM_THREADS | Active-thread mask, bit k is thread k |
| occ_i | input | NUM_THREADS x CNT_W | Per-thread occupancy reported by the buffer |
| limit_o | output | NUM_THREADS x CNT_W | Registered per-thread limit |
| free_o | output | NUM_THREADS x CNT_W | Per-thread free entries, saturated at 0 |
| total_free_o | output | CNT_W | Global free entries, saturated at 0 |
| policy_err_o | output | 1 | High while the policy code is undefined |

## Verification
The following properties are checked on every cycle:
- the limits hold still whenever the mask is steady, or is zero, or the policy code is undefined;
- each free count stays consistent with its limit and occupancy, including the saturation at 0;
- the global free count never exceeds the capacity.

The actual values written at a recompute cannot be shown by those properties and are left to the bench scenarios. These are the truncated division among active threads, the full-buffer grant to a lone thread under the cap policy, and the untouched limits of inactive threads. The same holds for the reset loads per policy and for a chain of successive mask changes.

// File: rtl/rob_alloc_pkg.sv
package rob_alloc_pkg;

    localparam int unsigned MAX_THREADS = 32;

    typedef enum logic [1:0] {
        POL_SHARED = 2'd0,
        POL_SPLIT  = 2'd1,
        POL_CAP    = 2'd2
    } share_pol_e;

    typedef struct packed {
        share_pol_e mode;
        logic       bad;
    } pol_dec_t;

    // Undefined codes fall back to the shared policy and are flagged.
    function automatic pol_dec_t decode_pol(input logic [1:0] raw);
        pol_dec_t d;
        case (raw)
            2'd0:    begin d.mode = POL_SHARED; d.bad = 1'b0; end
            2'd1:    begin d.mode = POL_SPLIT;  d.bad = 1'b0; end
            2'd2:    begin d.mode = POL_CAP;    d.bad = 1'b0; end
            default: begin d.mode = POL_SHARED; d.bad = 1'b1; end
        endcase
        return d;
    endfunction

    function automatic int unsigned count_ones32(input logic [31:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/alloc_limit_calc.sv
module alloc_limit_calc
    import rob_alloc_pkg::*;
#(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned TC_W        = 3
) (
    input  share_pol_e                          mode_i,
    input  logic [CNT_W-1:0]                    cap_i,
    input  logic [CNT_W-1:0]                    thr_i,
    input  logic [NUM_THREADS-1:0]              active_i,
    input  logic [TC_W-1:0]                     act_cnt_i,
    input  logic [NUM_THREADS-1:0][CNT_W-1:0]   cur_lim_i,
    output logic [NUM_THREADS-1:0][CNT_W-1:0]   init_lim_o,
    output logic [NUM_THREADS-1:0][CNT_W-1:0]   upd_lim_o
);
    localparam logic [CNT_W-1:0] THREADS_C = CNT_W'(NUM_THREADS);

    logic [CNT_W-1:0] even_share;
    logic [CNT_W-1:0] live_share;
    logic             lone_thread;

    always_comb begin
        even_share  = cap_i / THREADS_C;
        lone_thread = (act_cnt_i == TC_W'(1));
        if (act_cnt_i == '0) begin
            live_share = cap_i;
        end else begin
            live_share = cap_i / CNT_W'(act_cnt_i);
        end
    end

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        always_comb begin
            case (mode_i)
                POL_SPLIT: init_lim_o[t] = even_share;
                POL_CAP:   init_lim_o[t] = thr_i;
                default:   init_lim_o[t] = cap_i;
            endcase

            upd_lim_o[t] = cur_lim_i[t];
            if (active_i[t]) begin
                case (mode_i)
                    POL_SPLIT: upd_lim_o[t] = live_share;
                    POL_CAP:   if (lone_thread) upd_lim_o[t] = cap_i;
                    default:   upd_lim_o[t] = cur_lim_i[t];
                endcase
            end
        end
    end

endmodule

// File: rtl/alloc_free_calc.sv
module alloc_free_calc #(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned CNT_W       = 8
) (
    input  logic [CNT_W-1:0]                    cap_i,
    input  logic [NUM_THREADS-1:0][CNT_W-1:0]   lim_i,
    input  logic [NUM_THREADS-1:0][CNT_W-1:0]   occ_i,
    output logic [NUM_THREADS-1:0][CNT_W-1:0]   free_o,
    output logic [CNT_W-1:0]                    total_free_o
);
    localparam int unsigned SUM_W = CNT_W + $clog2(NUM_THREADS + 1);

    logic [SUM_W-1:0] occ_sum;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_free
        always_comb begin
            if (occ_i[t] > lim_i[t]) begin
                free_o[t] = '0;
            end else begin
                free_o[t] = lim_i[t] - occ_i[t];
            end
        end
    end

    always_comb begin
        occ_sum = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            occ_sum += SUM_W'(occ_i[t]);
        end
        if (occ_sum > SUM_W'(cap_i)) begin
            total_free_o = '0;
        end else begin
            total_free_o = CNT_W'(SUM_W'(cap_i) - occ_sum);
        end
    end

endmodule

// File: rtl/rob_share_alloc.sv
module rob_share_alloc
    import rob_alloc_pkg::*;
#(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned MAX_ENTRIES = 192,
    localparam int unsigned CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [1:0]                          policy_i,
    input  logic [CNT_W-1:0]                    capacity_i,
    input  logic [CNT_W-1:0]                    threshold_i,
    input  logic [NUM_THREADS-1:0]              active_i,
    input  logic [NUM_THREADS-1:0][CNT_W-1:0]   occ_i,
    output logic [NUM_THREADS-1:0][CNT_W-1:0]   limit_o,
    output logic [NUM_THREADS-1:0][CNT_W-1:0]   free_o,
    output logic [CNT_W-1:0]                    total_free_o,
    output logic                                policy_err_o
);
    localparam int unsigned TC_W = $clog2(NUM_THREADS + 1);
    localparam bit SINGLE_CFG    = (NUM_THREADS == 1);

    pol_dec_t                           dec;
    logic [TC_W-1:0]                    act_cnt;
    logic [NUM_THREADS-1:0]             mask_q;
    logic [NUM_THREADS-1:0][CNT_W-1:0]  lim_q;
    logic [NUM_THREADS-1:0][CNT_W-1:0]  init_lim;
    logic [NUM_THREADS-1:0][CNT_W-1:0]  upd_lim;
    logic                               mask_chg;
    logic                               may_update;

    always_comb begin
        dec        = decode_pol(policy_i);
        act_cnt    = TC_W'(count_ones32(32'(active_i)));
        mask_chg   = (active_i != mask_q);
        may_update = mask_chg && (act_cnt != '0)
                     && !(dec.mode == POL_SHARED && SINGLE_CFG);
    end

    alloc_limit_calc #(
        .NUM_THREADS (NUM_THREADS),
        .CNT_W       (CNT_W),
        .TC_W        (TC_W)
    ) u_calc (
        .mode_i     (dec.mode),
        .cap_i      (capacity_i),
        .thr_i      (threshold_i),
        .active_i   (active_i),
        .act_cnt_i  (act_cnt),
        .cur_lim_i  (lim_q),
        .init_lim_o (init_lim),
        .upd_lim_o  (upd_lim)
    );

    always_ff @(posedge clk) begin
        mask_q <= active_i;
        if (rst) begin
            lim_q <= init_lim;
        end else if (may_update) begin
            lim_q <= upd_lim;
        end
    end

    alloc_free_calc #(
        .NUM_THREADS (NUM_THREADS),
        .CNT_W       (CNT_W)
    ) u_free (
        .cap_i        (capacity_i),
        .lim_i        (lim_q),
        .occ_i        (occ_i),
        .free_o       (free_o),
        .total_free_o (total_free_o)
    );

    assign limit_o      = lim_q;
    assign policy_err_o = dec.bad;

endmodule

// File: rtl/rob_share_alloc_chk.sv
module rob_share_alloc_chk #(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned CNT_W       = 8
) (
    input logic                                clk,
    input logic                                rst,
    input logic [CNT_W-1:0]                    capacity_i,
    input logic [NUM_THREADS-1:0]              active_i,
    input logic [NUM_THREADS-1:0][CNT_W-1:0]   occ_i,
    input logic [NUM_THREADS-1:0][CNT_W-1:0]   limit_o,
    input logic [NUM_THREADS-1:0][CNT_W-1:0]   free_o,
    input logic [CNT_W-1:0]                    total_free_o,
    input logic                                policy_err_o
);
    assert_steady_mask_R9: assert property (@(posedge clk) disable iff (rst)
        (active_i == $past(active_i)) |=> $stable(limit_o));

    assert_zero_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (active_i == '0) |=> $stable(limit_o));

    assert_bad_code_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        policy_err_o |=> $stable(limit_o));

    assert_total_bound_R7: assert property (@(posedge clk) disable iff (rst)
        total_free_o <= capacity_i);

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
        assert_free_sum_R6: assert property (@(posedge clk) disable iff (rst)
            (occ_i[t] <= limit_o[t]) |->
            ((CNT_W+1)'(free_o[t]) + (CNT_W+1)'(occ_i[t]) == (CNT_W+1)'(limit_o[t])));

        assert_free_sat_R6: assert property (@(posedge clk) disable iff (rst)
            (occ_i[t] > limit_o[t]) |-> (free_o[t] == '0));
    end

endmodule

bind rob_share_alloc rob_share_alloc_chk #(
    .NUM_THREADS (NUM_THREADS),
    .CNT_W       (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .capacity_i   (capacity_i),
    .active_i     (active_i),
    .occ_i        (occ_i),
    .limit_o      (limit_o),
    .free_o       (free_o),
    .total_free_o (total_free_o),
    .policy_err_o (policy_err_o)
);

// File: tb/sim_rob_share_alloc.sv
module sim_rob_share_alloc;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned NT = 4;
    localparam int unsigned CW = 8;

    logic                 clk = 1'b0;
    logic                 rst;
    logic [1:0]           policy;
    logic [CW-1:0]        cap;
    logic [CW-1:0]        thr;
    logic [NT-1:0]        active;
    logic [NT-1:0][CW-1:0] occ;
    logic [NT-1:0][CW-1:0] lim;
    logic [NT-1:0][CW-1:0] fr;
    logic [CW-1:0]        tfree;
    logic                 perr;

    int compared   = 0;
    int mismatched = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rob_share_alloc #(.NUM_THREADS(NT), .MAX_ENTRIES(192)) u0 (
        .clk(clk), .rst(rst), .policy_i(policy), .capacity_i(cap),
        .threshold_i(thr), .active_i(active), .occ_i(occ), .limit_o(lim),
        .free_o(fr), .total_free_o(tfree), .policy_err_o(perr)
    );

    // {policy, mask, limit t3, t2, t1, t0}; capacity 100, threshold 30
    localparam logic [37:0] VEC [0:7] = '{
        {2'd1, 4'b0011, 8'd25,  8'd25,  8'd50,  8'd50 },  // R3 two active
        {2'd1, 4'b0111, 8'd25,  8'd33,  8'd33,  8'd33 },  // R3 truncation
        {2'd1, 4'b1010, 8'd50,  8'd25,  8'd50,  8'd25 },  // R3 inactive kept
        {2'd1, 4'b0000, 8'd25,  8'd25,  8'd25,  8'd25 },  // R5 empty mask
        {2'd2, 4'b0100, 8'd30,  8'd100, 8'd30,  8'd30 },  // R4 lone thread
        {2'd2, 4'b0110, 8'd30,  8'd30,  8'd30,  8'd30 },  // R4 two active
        {2'd0, 4'b0001, 8'd100, 8'd100, 8'd100, 8'd100},  // R2 shared
        {2'd3, 4'b1000, 8'd100, 8'd100, 8'd100, 8'd100}   // R8 undefined
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] pol);
        @(negedge clk);
        rst    = 1'b1;
        policy = pol;
        active = 4'b1111;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_mask(input logic [NT-1:0] m);
        active = m;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; policy = 2'd0; cap = 8'd100; thr = 8'd30;
        active = 4'b1111; occ = '0;

        // R1 reset loads per policy
        do_reset(2'd1);
        check("R1 split reset", 64'(lim), 64'({8'd25, 8'd25, 8'd25, 8'd25}));
        check("R8 flag low", 64'(perr), 64'd0);
        do_reset(2'd2);
        check("R1 cap reset", 64'(lim), 64'({8'd30, 8'd30, 8'd30, 8'd30}));
        do_reset(2'd3);
        check("R1 undefined reset", 64'(lim), 64'({8'd100, 8'd100, 8'd100, 8'd100}));
        check("R8 flag high", 64'(perr), 64'd1);

        // Vector table
        for (int i = 0; i < 8; i++) begin
            do_reset(VEC[i][37:36]);
            set_mask(VEC[i][35:32]);
            check($sformatf("R3/R4/R5/R2/R8 vector %0d", i), 64'(lim), 64'(VEC[i][31:0]));
        end

        // R3 chained changes, R9 stability
        do_reset(2'd1);
        set_mask(4'b0011);
        set_mask(4'b0001);
        check("R3 chained", 64'(lim), 64'({8'd25, 8'd25, 8'd50, 8'd100}));
        repeat (3) @(negedge clk);
        check("R9 steady mask", 64'(lim), 64'({8'd25, 8'd25, 8'd50, 8'd100}));

        // R4 lone grant survives a widening change
        do_reset(2'd2);
        set_mask(4'b0100);
        set_mask(4'b0110);
        check("R4 kept after widen", 64'(lim), 64'({8'd30, 8'd100, 8'd30, 8'd30}));

        // R2 shared over several changes
        do_reset(2'd0);
        set_mask(4'b0010);
        set_mask(4'b1100);
        set_mask(4'b1111);
        check("R2 shared stays", 64'(lim), 64'({8'd100, 8'd100, 8'd100, 8'd100}));

        // R6 / R7 free counts with limits 25,25,50,50
        do_reset(2'd1);
        set_mask(4'b0011);
        occ = {8'd30, 8'd5, 8'd50, 8'd10};
        #1;
        check("R6 free mixed", 64'(fr), 64'({8'd0, 8'd20, 8'd0, 8'd40}));
        check("R7 total free", 64'(tfree), 64'd5);
        occ = {8'd40, 8'd40, 8'd40, 8'd40};
        #1;
        check("R6 free saturate", 64'(fr), 64'({8'd0, 8'd0, 8'd10, 8'd10}));
        check("R7 total saturate", 64'(tfree), 64'd0);
        occ = '0;
        #1;
        check("R7 empty buffer", 64'(tfree), 64'd100);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule